// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block watches the byte stream of received Ethernet frames (preamble already stripped) and decides, from the six-byte destination address at the head of each frame, whether the frame should be kept or thrown away. Bytes arrive one per accepted beat, with start-of-frame and end-of-frame markers. The block does not hold the frame. It issues one decision per frame: a keep/discard bit plus a code saying which rule matched. A frame buffer downstream uses that decision to commit or discard what it has stored.

The filter settings are plain inputs from a configuration register bank: a primary station address, four extra unicast addresses, a pass-everything bit and a 64-bit table of multicast bins. All of them are sampled on the start-of-frame beat and held for the rest of that frame. Software can therefore rewrite them at any time without splitting the decision for a frame already in progress.

Top module: `rx_addr_filter`

## Requirements
- R1: Address inputs hold the first received destination byte in bits [7:0], the second in bits [15:8], and so on up to the sixth in bits [47:40]. A frame whose destination equals the primary address is kept with class code 1.
- R2: A frame that no rule accepts is discarded with class code 0. This includes unicast frames that match no address and multicast frames whose table bin is 0. Whenever the decision strobe is high, keep is 1 exactly when the class is not 0.
- R3: A destination of all 48 ones is kept with class code 3, whatever the multicast table holds.
- R4: A destination equal to any one of the four extra addresses (packed four by 48 bits, entry k at bits [48k+47:48k]) is kept with class code 2.
- R5: With the pass-everything bit set, every frame of at least six bytes is kept with class code 5.
- R6: A destination with bit 0 set that is not all ones selects a bin of the multicast table. The bin index is the low 6 bits of a CRC-32 register run over the six destination bytes, each byte least significant bit first. The register starts at all ones, uses the reflected polynomial 0xEDB88320 and is not inverted at the end. If that bin is 1, the frame is kept with class code 4.
- R7: When several rules apply, the class reported follows this priority: pass-everything, then broadcast, then primary, then extra address, then multicast bin.
- R8: A byte counts only on a beat with the valid input high. The decision strobe is high for exactly one cycle, the cycle after the beat that carries the sixth destination byte. Later bytes and the end marker of that frame produce no further decision.
- R9: A frame whose end marker arrives on one of its first five bytes, including a single-beat frame with both markers set, gets a strobe in the cycle after that end beat, with keep 0 and class 0.
- R10: All filter settings are sampled on the start-of-frame beat. A change later in the frame does not affect that frame's decision but does apply to the next frame.
- R11: During and straight after reset, the strobe, keep and class outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_primary | input | 48 | Primary station address |
| cfg_extra | input | 192 | Four extra unicast addresses, packed |
| cfg_promisc | input | 1 | Pass-everything enable |
| cfg_hash | input | 64 | Multicast bin table |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = keep frame, 0 = discard |
| dec_class | output | 3 | Matching rule: 0 none, 1 primary, 2 extra, 3 broadcast, 4 multicast bin, 5 pass-everything |

## Verification
A wrong byte counter shows up within one frame. The strobe either arrives a cycle early or late, fires twice, or fires on a short frame's end marker at the wrong time. A corrupted assembled address or CRC register shows up as a wrong class on that same frame's strobe, for example a multicast frame landing in the wrong bin. A stale or overwritten settings snapshot only shows up when the settings change between or inside frames. For that reason the bench rewrites them in the middle of a frame and compares two consecutive frames. A cycle-level model compares the strobe, keep bit and class on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_PRIMARY = 3'd1,
        CLS_EXTRA   = 3'd2,
        CLS_BCAST   = 3'd3,
        CLS_HASH    = 3'd4,
        CLS_PROMISC = 3'd5
    } match_cls_e;

    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rxf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o
);

    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_i;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ data_i[k]) begin
                c = (c >> 1) ^ CRC_POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        crc_o = c;
    end

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
    parameter int unsigned ADDR_W  = 48,
    parameter int unsigned N_EXTRA = 4
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [ADDR_W-1:0]         primary_i,
    input  logic [N_EXTRA*ADDR_W-1:0] extra_i,
    output logic                      hit_primary_o,
    output logic                      hit_extra_o
);

    logic [N_EXTRA-1:0] extra_hit;

    for (genvar g = 0; g < N_EXTRA; g++) begin : g_extra
        assign extra_hit[g] = (addr_i == extra_i[g*ADDR_W +: ADDR_W]);
    end

    assign hit_primary_o = (addr_i == primary_i);
    assign hit_extra_o   = |extra_hit;

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 48,
    parameter int unsigned HASH_IDX_W = 6,
    localparam int unsigned HASH_N    = 1 << HASH_IDX_W
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  promisc_i,
    input  logic                  hit_primary_i,
    input  logic                  hit_extra_i,
    input  logic [HASH_N-1:0]     hash_tbl_i,
    input  logic [HASH_IDX_W-1:0] hash_idx_i,
    output logic                  accept_o,
    output match_cls_e            cls_o
);

    logic is_bcast;
    logic is_mcast;

    assign is_bcast = &addr_i;
    assign is_mcast = addr_i[0];

    always_comb begin
        if (promisc_i) begin
            cls_o = CLS_PROMISC;
        end else if (is_bcast) begin
            cls_o = CLS_BCAST;
        end else if (hit_primary_i) begin
            cls_o = CLS_PRIMARY;
        end else if (hit_extra_i) begin
            cls_o = CLS_EXTRA;
        end else if (is_mcast && hash_tbl_i[hash_idx_i]) begin
            cls_o = CLS_HASH;
        end else begin
            cls_o = CLS_NONE;
        end
        accept_o = (cls_o != CLS_NONE);
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned N_EXTRA    = 4,
    parameter int unsigned HASH_IDX_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              in_sof,
    input  logic                              in_eof,
    input  logic [7:0]                        in_byte,
    input  logic [ADDR_BYTES*8-1:0]           cfg_primary,
    input  logic [N_EXTRA*ADDR_BYTES*8-1:0]   cfg_extra,
    input  logic                              cfg_promisc,
    input  logic [(1<<HASH_IDX_W)-1:0]        cfg_hash,
    output logic                              dec_valid,
    output logic                              dec_accept,
    output logic [2:0]                        dec_class
);

    localparam int unsigned ADDR_W = ADDR_BYTES * 8;
    localparam int unsigned HASH_N = 1 << HASH_IDX_W;
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic                        active;
        logic [CNT_W-1:0]            cnt;
        logic [ADDR_W-1:0]           addr;
        logic [CRC_W-1:0]            crc;
        logic [ADDR_W-1:0]           snap_primary;
        logic [N_EXTRA*ADDR_W-1:0]   snap_extra;
        logic                        snap_promisc;
        logic [HASH_N-1:0]           snap_hash;
        logic                        dv;
        logic                        acc;
        match_cls_e                  cls;
    } state_t;

    state_t q, d;

    logic [CRC_W-1:0]  crc_seed, crc_next;
    logic [ADDR_W-1:0] addr_full;
    logic              hit_primary, hit_extra, cls_accept;
    match_cls_e        cls_calc;

    assign crc_seed = in_sof ? '1 : q.crc;

    always_comb begin
        addr_full = q.addr;
        addr_full[ADDR_W-8 +: 8] = in_byte;
    end

    rxf_crc_byte u_crc (
        .crc_i  (crc_seed),
        .data_i (in_byte),
        .crc_o  (crc_next)
    );

    rxf_addr_match #(
        .ADDR_W  (ADDR_W),
        .N_EXTRA (N_EXTRA)
    ) u_match (
        .addr_i        (addr_full),
        .primary_i     (q.snap_primary),
        .extra_i       (q.snap_extra),
        .hit_primary_o (hit_primary),
        .hit_extra_o   (hit_extra)
    );

    rxf_classify #(
        .ADDR_W     (ADDR_W),
        .HASH_IDX_W (HASH_IDX_W)
    ) u_cls (
        .addr_i        (addr_full),
        .promisc_i     (q.snap_promisc),
        .hit_primary_i (hit_primary),
        .hit_extra_i   (hit_extra),
        .hash_tbl_i    (q.snap_hash),
        .hash_idx_i    (crc_next[HASH_IDX_W-1:0]),
        .accept_o      (cls_accept),
        .cls_o         (cls_calc)
    );

    always_comb begin
        d     = q;
        d.dv  = 1'b0;
        d.acc = 1'b0;
        d.cls = CLS_NONE;
        if (in_valid) begin
            if (in_sof) begin
                d.snap_primary = cfg_primary;
                d.snap_extra   = cfg_extra;
                d.snap_promisc = cfg_promisc;
                d.snap_hash    = cfg_hash;
                d.addr         = '0;
                d.addr[7:0]    = in_byte;
                d.crc          = crc_next;
                d.cnt          = CNT_W'(1);
                d.active       = !in_eof;
                d.dv           = in_eof;
            end else if (q.active) begin
                d.addr[q.cnt*8 +: 8] = in_byte;
                d.crc                = crc_next;
                d.cnt                = q.cnt + CNT_W'(1);
                if (q.cnt == LAST_IDX) begin
                    d.active = 1'b0;
                    d.dv     = 1'b1;
                    d.acc    = cls_accept;
                    d.cls    = cls_calc;
                end else if (in_eof) begin
                    d.active = 1'b0;
                    d.dv     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dec_valid  = q.dv;
    assign dec_accept = q.acc;
    assign dec_class  = q.cls;

    // R2: keep bit agrees with the reported class
    assert_keep_matches_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_class != CLS_NONE)));

    // R3: broadcast class only for an all-ones destination
    assert_bcast_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == CLS_BCAST) |-> (&q.addr));

    // R6: bin class only for a group destination
    assert_hash_needs_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == CLS_HASH) |-> q.addr[0]);

    // R8: a decision always follows a valid byte beat
    assert_strobe_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid));

    // R9: a single-beat frame is discarded on the next cycle
    assert_single_beat_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_eof) |=> (dec_valid && !dec_accept && dec_class == CLS_NONE));

    // R9: an end marker on an early address byte gives a discard
    assert_short_frame_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && in_eof && q.active && q.cnt != LAST_IDX)
        |=> (dec_valid && !dec_accept));

endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]   in_byte = '0;
    logic [47:0]  cfg_primary = '0;
    logic [191:0] cfg_extra = '0;
    logic         cfg_promisc = 1'b0;
    logic [63:0]  cfg_hash = '0;
    logic         dec_valid, dec_accept;
    logic [2:0]   dec_class;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_byte,
        .cfg_primary, .cfg_extra, .cfg_promisc, .cfg_hash,
        .dec_valid, .dec_accept, .dec_class
    );

    // ---------------- behavioural reference ----------------
    function automatic int hash_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return int'(c[5:0]);
    endfunction

    function automatic int classify(input logic [47:0] a, input logic [47:0] p,
                                    input logic [191:0] x, input logic pr, input logic [63:0] h);
        bit ex = 0;
        for (int k = 0; k < 4; k++) if (x[k*48 +: 48] == a) ex = 1;
        if (pr)                         return 5;
        if (a == '1)                    return 3;
        if (a == p)                     return 1;
        if (ex)                         return 2;
        if (a[0] && h[hash_index(a)])   return 4;
        return 0;
    endfunction

    int           m_cnt = 0;
    bit           m_active = 0;
    logic [47:0]  m_addr;
    logic [47:0]  s_primary;
    logic [191:0] s_extra;
    logic         s_promisc;
    logic [63:0]  s_hash;
    bit           exp_dv = 0;
    int           exp_cls = 0;

    always @(posedge clk) begin
        exp_dv  = 0;
        exp_cls = 0;
        if (!rst_n) begin
            m_active = 0;
            m_cnt    = 0;
        end else if (in_valid) begin
            if (in_sof) begin
                s_primary = cfg_primary; s_extra = cfg_extra;
                s_promisc = cfg_promisc; s_hash  = cfg_hash;
                m_addr = '0;
                m_addr[7:0] = in_byte;
                m_cnt = 1;
                m_active = !in_eof;
                exp_dv = in_eof;
            end else if (m_active) begin
                m_addr[m_cnt*8 +: 8] = in_byte;
                m_cnt++;
                if (m_cnt == 6) begin
                    m_active = 0;
                    exp_dv = 1;
                    exp_cls = classify(m_addr, s_primary, s_extra, s_promisc, s_hash);
                end else if (in_eof) begin
                    m_active = 0;
                    exp_dv = 1;
                end
            end
        end
    end

    function automatic string tag_of(input int c);
        case (c)
            1: return "R1"; 2: return "R4"; 3: return "R3";
            4: return "R6"; 5: return "R5"; default: return "R2";
        endcase
    endfunction

    bit   got_dec = 0;
    logic last_acc;
    int   last_cls;

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (dec_valid || dec_accept || dec_class != 3'd0) begin
                failures++;
                $display("FAIL R11 reset outputs: got %b/%b/%0d expected 0/0/0",
                         dec_valid, dec_accept, dec_class);
            end
        end else begin
            checks++;
            if (dec_valid !== exp_dv) begin
                failures++;
                $display("FAIL R8 strobe: got %b expected %b", dec_valid, exp_dv);
            end else if (exp_dv && (dec_accept !== (exp_cls != 0) || int'(dec_class) != exp_cls)) begin
                failures++;
                $display("FAIL %s decision: got acc=%b cls=%0d expected acc=%b cls=%0d",
                         tag_of(exp_cls), dec_accept, dec_class, exp_cls != 0, exp_cls);
            end
            if (dec_valid) begin
                got_dec  = 1;
                last_acc = dec_accept;
                last_cls = int'(dec_class);
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] frm[$];

    task automatic build(input logic [47:0] a, input int payload);
        frm.delete();
        for (int i = 0; i < 6; i++) frm.push_back(a[i*8 +: 8]);
        for (int i = 0; i < payload; i++) frm.push_back(8'(i * 7 + 3));
    endtask

    task automatic send(input int gap, input int mut_at, input logic [47:0] mut_val);
        got_dec = 0;
        foreach (frm[i]) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = (i == frm.size() - 1);
            in_byte = frm[i];
            if (i == mut_at) cfg_primary = mut_val;
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 0; in_sof = 0; in_eof = 0;
            end
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_last(input string tag, input logic e_acc, input int e_cls);
        checks++;
        if (!got_dec || last_acc !== e_acc || last_cls != e_cls) begin
            failures++;
            $display("FAIL %s: got dec=%b acc=%b cls=%0d expected dec=1 acc=%b cls=%0d",
                     tag, got_dec, last_acc, last_cls, e_acc, e_cls);
        end
    endtask

    localparam logic [47:0] PRIM  = 48'h665544332210;
    localparam logic [47:0] OTHER = 48'h123456789A0C;
    localparam logic [47:0] GRP   = 48'h0C0B0A090807;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    function automatic logic [47:0] extra_addr(input int k);
        return 48'h0A0B0C0D0E02 + 48'(k) * 48'h000100000100;
    endfunction

    initial begin
        cfg_primary = PRIM;
        for (int k = 0; k < 4; k++) cfg_extra[k*48 +: 48] = extra_addr(k);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        build(PRIM, 10);  send(0, -1, '0); check_last("R1 primary match", 1, 1);
        build(OTHER, 10); send(0, -1, '0); check_last("R2 unmatched unicast", 0, 0);
        for (int k = 0; k < 4; k++) begin
            build(extra_addr(k), 4); send(0, -1, '0);
            check_last("R4 extra address", 1, 2);
        end
        build(BCAST, 3); send(0, -1, '0); check_last("R3 broadcast, empty table", 1, 3);

        cfg_hash = 64'd1 << hash_index(GRP);
        build(GRP, 5); send(0, -1, '0); check_last("R6 bin set", 1, 4);
        cfg_hash = ~(64'd1 << hash_index(GRP));
        build(GRP, 5); send(0, -1, '0); check_last("R6 other bins set", 0, 0);
        cfg_hash = '0;

        cfg_extra[0 +: 48] = PRIM;
        build(PRIM, 2); send(0, -1, '0); check_last("R7 primary over extra", 1, 1);
        cfg_extra[0 +: 48] = extra_addr(0);

        cfg_promisc = 1;
        build(OTHER, 2); send(0, -1, '0); check_last("R5 pass-everything", 1, 5);
        build(BCAST, 2); send(0, -1, '0); check_last("R7 promisc over broadcast", 1, 5);
        frm.delete(); frm.push_back(8'h10); frm.push_back(8'h22);
        send(0, -1, '0); check_last("R9 short frame under promisc", 0, 0);
        cfg_promisc = 0;

        build(PRIM, 0); frm = frm[0:2]; send(0, -1, '0); check_last("R9 three-byte frame", 0, 0);
        frm.delete(); frm.push_back(8'h10); send(0, -1, '0); check_last("R9 single beat", 0, 0);

        build(PRIM, 6); send(1, -1, '0); check_last("R8 gaps between bytes", 1, 1);
        build(PRIM, 0); send(0, -1, '0); check_last("R8 exact six bytes", 1, 1);

        build(PRIM, 6); send(0, 2, OTHER); check_last("R10 change mid-frame ignored", 1, 1);
        build(PRIM, 6); send(0, -1, '0); check_last("R10 change applies next frame", 0, 0);
        cfg_primary = PRIM;

        // back-to-back frames with no idle cycle
        got_dec = 0;
        build(OTHER, 1); frm.push_back(8'hFF); frm.push_back(8'hFF);
        for (int i = 0; i < 6; i++) frm.push_back(PRIM[i*8 +: 8]);
        foreach (frm[i]) begin
            @(negedge clk);
            in_valid = 1; in_byte = frm[i];
            in_sof = (i == 0 || i == 9); in_eof = (i == 8 || i == 14);
        end
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (2) @(negedge clk);
        check_last("R8 back-to-back second frame", 1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule